// File: doc/BRIEF.md
# Synchronous SCL Stretch Injector

This block works around a two-wire serial controller that produces a runt clock pulse when it resumes after a target holds the clock line low. It adds a clock stretch of its own that starts and ends at fixed times. A counter runs in the controller's own clock domain, so the injected low is synchronous to the controller's bit timing.

The counter starts when the controller signals that a transmit or a receive has begun. It pulls a spare open-drain line wired to SCL low when the count reaches a programmed assert value. It releases the line when the count reaches a programmed release value. At the release value the count also returns to zero, so the low window repeats once in every release interval. Choose the release interval to match the byte period, and make the low window longer than the longest stretch any target is expected to apply. The window is then injected in every byte, whether or not the target asks for a stretch.

When the controller signals that it has stopped, the counter halts and clears, and the line is released. The compare values are captured only when a transfer starts. A capture with a bad ordering of the two values is flagged and keeps the line released. A status output tells whether the block is idle, counting with the line released, or counting with the line pulled.

Top module: `stretch_injector`

## Requirements
- R1: After reset the open-drain enable is 0 (line released), status is 0 (idle) and the configuration error flag is 0.
- R2: While idle, a single-cycle pulse on either the transmit-start or the receive-start input starts counting, provided the captured values satisfy 0 < assert value < release value. Status reads 1 in the following cycle.
- R3: The open-drain enable rises exactly assert-value clock edges after the start edge. From idle, status never goes directly to 2.
- R4: The enable falls exactly release-value edges after the start edge, and the counter restarts at that same edge. The enable then rises again at release+assert edges and falls at 2*release edges, and this continues with period release value.
- R5: A stop pulse makes the block idle with the line released at the next edge, from any state. When stop and a start pulse arrive in the same cycle, stop wins and no counting begins.
- R6: A start pulse while counting is ignored: the timing of the edges continues unchanged.
- R7: The compare inputs are captured only at an accepted start. Changing them while counting has no effect on the edge times.
- R8: A start while idle with assert value 0, or with assert value >= release value, sets the error flag and leaves the block idle with the line released. The next accepted start clears the flag.
- R9: Status encoding: 0 idle, 1 counting with line released, 2 counting with line pulled low. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the serial controller |
| rstN | input | 1 | Active-low reset |
| txStarted | input | 1 | Single-cycle pulse: controller began a transmit |
| rxStarted | input | 1 | Single-cycle pulse: controller began a receive |
| stopped | input | 1 | Single-cycle pulse: controller finished the transfer |
| cmpAssert | input | CNT_W | Count at which the line is pulled low |
| cmpRelease | input | CNT_W | Count at which the line is released and the counter restarts |
| sclPullEn | output | 1 | 1 drives the open-drain stretch line low, 0 leaves it high-impedance |
| cfgError | output | 1 | Last start was rejected for a bad compare ordering |
| status | output | 2 | 0 idle, 1 counting released, 2 counting pulled |

## Verification
The assertions take two things for granted. The three event inputs are synchronous to clk and settle before each edge, and the compare inputs hold steady around the edge at which a start is accepted. The bench drives every input only on the falling edge, so they settle half a period before the rising edge that samples them. It changes the compare values either while the block is idle or in the middle of a run, where they must have no effect. The stimulus deliberately includes start and stop in the same cycle, starts while counting, the tightest legal compare pair, and both kinds of illegal pair. These cases cover the priority and rejection rules that the assertions relate.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RELEASED = 2'd1,
    ST_PULLED   = 2'd2
  } stretchState_e;

  typedef struct packed {
    logic load;   // capture compares and zero the count
    logic clear;  // zero the count
    logic step;   // advance the count by one
  } cntCtrl_t;
endpackage

// File: rtl/stretch_timer.sv
module stretch_timer
  import stretch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctrl,
  input  logic [CNT_W-1:0] cmpAssertIn,
  input  logic [CNT_W-1:0] cmpReleaseIn,
  output logic             cfgValid,
  output logic             hitAssert,
  output logic             hitRelease
);
  localparam int unsigned WideW = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmpAssertQ;
  logic [CNT_W-1:0] cmpReleaseQ;
  logic [WideW-1:0] countNext;

  assign countNext  = {1'b0, count} + WideW'(1);
  assign cfgValid   = (cmpAssertIn != '0) && (cmpAssertIn < cmpReleaseIn);
  assign hitAssert  = (countNext == {1'b0, cmpAssertQ});
  assign hitRelease = (countNext == {1'b0, cmpReleaseQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      cmpAssertQ  <= '0;
      cmpReleaseQ <= '0;
    end else if (ctrl.load) begin
      count       <= '0;
      cmpAssertQ  <= cmpAssertIn;
      cmpReleaseQ <= cmpReleaseIn;
    end else if (ctrl.clear) begin
      count <= '0;
    end else if (ctrl.step) begin
      count <= countNext[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/stretch_ctrl.sv
module stretch_ctrl
  import stretch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic          cfgValid,
  input  logic          hitAssert,
  input  logic          hitRelease,
  output cntCtrl_t      ctrl,
  output logic          pullEn,
  output logic          cfgError,
  output stretchState_e state
);
  logic running;
  logic acceptStart;

  assign acceptStart = !running && startEv && !stopEv;

  always_comb begin
    ctrl = '0;
    if (stopEv) begin
      ctrl.clear = 1'b1;
    end else if (acceptStart) begin
      ctrl.load = cfgValid;
    end else if (running) begin
      if (hitRelease) ctrl.clear = 1'b1;
      else            ctrl.step  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      pullEn   <= 1'b0;
      cfgError <= 1'b0;
    end else if (stopEv) begin
      running <= 1'b0;
      pullEn  <= 1'b0;
    end else if (acceptStart) begin
      running  <= cfgValid;
      cfgError <= !cfgValid;
      pullEn   <= 1'b0;
    end else if (running) begin
      if (hitRelease)     pullEn <= 1'b0;
      else if (hitAssert) pullEn <= 1'b1;
    end
  end

  always_comb begin
    if (!running)    state = ST_IDLE;
    else if (pullEn) state = ST_PULLED;
    else             state = ST_RELEASED;
  end
endmodule

// File: rtl/stretch_injector.sv
module stretch_injector
  import stretch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStarted,
  input  logic             rxStarted,
  input  logic             stopped,
  input  logic [CNT_W-1:0] cmpAssert,
  input  logic [CNT_W-1:0] cmpRelease,
  output logic             sclPullEn,
  output logic             cfgError,
  output logic [1:0]       status
);
  cntCtrl_t      ctrl;
  logic          cfgValid;
  logic          hitAssert;
  logic          hitRelease;
  stretchState_e state;

  stretch_timer #(.CNT_W(CNT_W)) uTimer (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cmpAssertIn (cmpAssert),
    .cmpReleaseIn(cmpRelease),
    .cfgValid    (cfgValid),
    .hitAssert   (hitAssert),
    .hitRelease  (hitRelease)
  );

  stretch_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startEv   (txStarted | rxStarted),
    .stopEv    (stopped),
    .cfgValid  (cfgValid),
    .hitAssert (hitAssert),
    .hitRelease(hitRelease),
    .ctrl      (ctrl),
    .pullEn    (sclPullEn),
    .cfgError  (cfgError),
    .state     (state)
  );

  assign status = state;
endmodule

// File: rtl/stretch_injector_checker.sv
module stretch_injector_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txStarted,
  input logic             rxStarted,
  input logic             stopped,
  input logic [CNT_W-1:0] cmpAssert,
  input logic [CNT_W-1:0] cmpRelease,
  input logic             sclPullEn,
  input logic             cfgError,
  input logic [1:0]       status
);
  logic startAny;
  logic goodCfg;
  assign startAny = txStarted | rxStarted;
  assign goodCfg  = (cmpAssert != '0) && (cmpAssert < cmpRelease);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0) |-> !sclPullEn);

  assert_start_counts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0 && startAny && !stopped && goodCfg) |=> (status == 2'd1 && !cfgError));

  assert_no_direct_pull_R3: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0) |=> (status != 2'd2));

  assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> (status == 2'd0 && !sclPullEn));

  assert_bad_cfg_rejected_R8: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0 && startAny && !stopped && !goodCfg) |=> (status == 2'd0 && cfgError));

  assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'd3);
endmodule

bind stretch_injector stretch_injector_checker #(.CNT_W(CNT_W)) uChecker (.*);

// File: tb/tb_stretch_injector.sv
module tb_stretch_injector;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             txStarted = 1'b0;
  logic             rxStarted = 1'b0;
  logic             stopped = 1'b0;
  logic [CNT_W-1:0] cmpAssert = '0;
  logic [CNT_W-1:0] cmpRelease = '0;
  logic             sclPullEn;
  logic             cfgError;
  logic [1:0]       status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phaseTag = "R1";

  always #2 clk = ~clk;

  stretch_injector #(.CNT_W(CNT_W)) dut (.*);

  // Behavioural reference: phase within the repeating period.
  bit mRun = 0;
  bit mErr = 0;
  int mPhase = 0;
  int mA = 0;
  int mR = 1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mErr = 0; mPhase = 0;
    end else if (stopped) begin
      mRun = 0;
    end else if (!mRun && (txStarted || rxStarted)) begin
      if (cmpAssert > 0 && cmpAssert < cmpRelease) begin
        mRun = 1; mErr = 0; mPhase = 0;
        mA = int'(cmpAssert); mR = int'(cmpRelease);
      end else begin
        mErr = 1;
      end
    end else if (mRun) begin
      mPhase = (mPhase + 1) % mR;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) t=%0t act=%0d exp=%0d", tag, phaseTag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expPull;
      int expStat;
      expPull = mRun && (mPhase >= mA);
      expStat = !mRun ? 0 : (expPull ? 2 : 1);
      check(sclPullEn == expPull, "R3/R4 pull edge timing", int'(sclPullEn), int'(expPull));
      check(int'(status) == expStat, "R9 status", int'(status), expStat);
      check(cfgError == mErr, "R8 error flag", int'(cfgError), int'(mErr));
    end
  end

  task automatic pulse(input bit tx, input bit rx, input bit st);
    @(negedge clk);
    txStarted = tx; rxStarted = rx; stopped = st;
    @(negedge clk);
    txStarted = 0; rxStarted = 0; stopped = 0;
  endtask

  task automatic setCmp(input int a, input int r);
    @(negedge clk);
    cmpAssert = CNT_W'(a); cmpRelease = CNT_W'(r);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclPullEn == 0 && status == 0 && cfgError == 0, "R1 reset state",
          int'({cfgError, status, sclPullEn}), 0);

    phaseTag = "R2 tx start, R3 R4 period";
    setCmp(5, 12);
    pulse(1, 0, 0);
    idleCycles(40);

    phaseTag = "R6 start while counting";
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    idleCycles(10);

    phaseTag = "R7 compares changed while counting";
    setCmp(2, 3);
    idleCycles(30);

    phaseTag = "R5 stop while counting";
    pulse(0, 0, 1);
    check(status == 0 && sclPullEn == 0, "R5 idle after stop", int'(status), 0);
    idleCycles(4);

    phaseTag = "R2 rx start";
    setCmp(3, 4);
    pulse(0, 1, 0);
    idleCycles(15);
    pulse(0, 0, 1);

    phaseTag = "R5 stop beats start";
    setCmp(4, 9);
    pulse(1, 0, 1);
    check(status == 0, "R5 simultaneous stop and start", int'(status), 0);
    idleCycles(5);

    phaseTag = "R8 assert equals release";
    setCmp(7, 7);
    pulse(1, 0, 0);
    check(cfgError == 1 && status == 0, "R8 rejected equal", int'({cfgError, status}), 4);
    idleCycles(5);

    phaseTag = "R8 assert zero";
    setCmp(0, 7);
    pulse(0, 1, 0);
    idleCycles(5);

    phaseTag = "R8 assert above release";
    setCmp(9, 3);
    pulse(1, 0, 0);
    idleCycles(3);

    phaseTag = "R8 clear on valid, tightest pair";
    setCmp(1, 2);
    pulse(1, 0, 0);
    check(cfgError == 0, "R8 flag cleared", int'(cfgError), 0);
    idleCycles(12);

    phaseTag = "R5 stop while pulled";
    setCmp(6, 40);
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    idleCycles(10);
    check(sclPullEn == 1, "R3 pulled mid window", int'(sclPullEn), 1);
    pulse(0, 0, 1);
    check(sclPullEn == 0, "R5 released after stop", int'(sclPullEn), 0);

    phaseTag = "R4 long period";
    setCmp(90, 190);
    pulse(0, 1, 0);
    idleCycles(600);
    pulse(0, 0, 1);
    idleCycles(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 act=hung exp=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule